// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block derives a periodic interrupt request from a slow time base. A one-cycle strobe, `base_en`, marks each period of a 32.768 kHz reference inside the fast system clock domain. Each strobe advances a free-running 15-bit counter. A 4-bit rate code chooses a power-of-two period. When the counter reaches a multiple of that period and the periodic enable is high, the block produces a one-cycle `tick_set` pulse. The same pulse sets two sticky flags: the periodic-event flag and the summary "interrupt pending" flag.

The counter never restarts when the rate code changes. Because of this, every tick stays aligned to a multiple of the selected period, counted from reset. Software reads the status and issues `stat_clr` to drop both flags. If a tick and a clear happen in the same cycle, the tick wins, so no event is lost.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset `tick_set`, `flag_periodic` and `flag_summary` are 0, and the base counter is zero. The first tick with rate code n therefore comes on the strobe that brings the number of strobes since reset to a multiple of the period.
- R2: Rate code 0 produces no ticks.
- R3: For rate codes 3 to 15, the period is 2^(n-1) strobes of `base_en`. A tick is produced on the strobe that brings the strobe count since reset (mod 32768) to a multiple of the period.
- R4: Rate codes 1 and 2 select the slow periods of 128 and 256 strobes, the same as codes 8 and 9.
- R5: When `pie_en` is 0, no tick is produced, but the counter keeps advancing.
- R6: Changing the rate code does not restart the count. The next tick comes at the next multiple of the new period.
- R7: `tick_set` is high for exactly one cycle. It rises on the clock edge that samples the matching `base_en` strobe.
- R8: A tick sets both `flag_periodic` and `flag_summary` on the same edge. The two flags stay set until a `stat_clr` is sampled.
- R9: If `stat_clr` and a tick fall on the same edge, both flags end up set.
- R10: In a cycle with `base_en` low, the counter holds and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle strobe per 32.768 kHz period |
| rate_code | input | 4 | Period selection code |
| pie_en | input | 1 | Periodic interrupt enable |
| stat_clr | input | 1 | Status clear pulse (read of the status register) |
| tick_set | output | 1 | One-cycle pulse that sets the flag bits |
| flag_periodic | output | 1 | Sticky periodic-event flag |
| flag_summary | output | 1 | Sticky interrupt-pending summary flag |

## Verification
The assertions assume that `base_en` is a strobe synchronous to `clk`. They also assume that the period is at least four strobes, so two ticks can never be adjacent. The rate code, the enable and the clear may change in any cycle. The stimulus drives all inputs on the falling edge, so each value is stable for a whole cycle. It sweeps every rate code with strobes dense and sparse. It changes the rate code without a reset, and it holds `stat_clr` high across tick cycles to force the clear/set collision.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned CNT_W  = 15;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SHW    = $clog2(CNT_W + 1);

  // number of low counter bits that must be zero at a tick
  function automatic logic [SHW-1:0] rate_shift(input logic [CODE_W-1:0] code,
                                                input int unsigned slow_a,
                                                input int unsigned slow_b);
    logic [SHW-1:0] s;
    case (code)
      '0:                 s = '0;
      CODE_W'(1):         s = SHW'(slow_a);
      CODE_W'(2):         s = SHW'(slow_b);
      default:            s = SHW'(code) - SHW'(1);
    endcase
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] low_mask(input logic [SHW-1:0] sh);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (one << sh) - one;
  endfunction
endpackage

// File: rtl/pid_free_counter.sv
module pid_free_counter #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_adv
);
  assign cnt_adv = step ? cnt + W'(1) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_adv;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/pid_rate_decode.sv
module pid_rate_decode
  import pid_pkg::*;
#(
  parameter int unsigned SLOW_A = 7,
  parameter int unsigned SLOW_B = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  logic [SHW-1:0] sh;
  always_comb begin
    sh     = rate_shift(code, SLOW_A, SLOW_B);
    active = (code != '0);
    mask   = low_mask(sh);
  end

  always_comb begin
    if (active) a_min_period_r3: assert (mask[1:0] == 2'b11);
  end
endmodule

// File: rtl/pid_tick_detect.sv
module pid_tick_detect #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         enable,
  input  logic         active,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] cnt_adv,
  output logic         hit,
  output logic         tick_q
);
  logic boundary;
  assign boundary = ((cnt_adv & mask) == '0);
  assign hit      = step & enable & active & boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= hit;
  end

  p_tick_needs_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(step));
  p_tick_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(enable) && $past(active));
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/pid_flag_reg.sv
module pid_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pf,
  output logic irqf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf   <= 1'b0;
      irqf <= 1'b0;
    end else if (set_i) begin
      pf   <= 1'b1;
      irqf <= 1'b1;
    end else if (clr_i) begin
      pf   <= 1'b0;
      irqf <= 1'b0;
    end
  end

  p_flags_paired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pf == irqf);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pf && irqf);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !pf);
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
  import pid_pkg::*;
#(
  parameter int unsigned SLOW_A = 7,
  parameter int unsigned SLOW_B = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              stat_clr,
  output logic              tick_set,
  output logic              flag_periodic,
  output logic              flag_summary
);
  logic [CNT_W-1:0] cnt, cnt_adv, mask;
  logic             active, hit;

  pid_free_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(base_en), .cnt(cnt), .cnt_adv(cnt_adv));

  pid_rate_decode #(.SLOW_A(SLOW_A), .SLOW_B(SLOW_B)) u_dec (
    .code(rate_code), .active(active), .mask(mask));

  pid_tick_detect #(.W(CNT_W)) u_det (
    .clk(clk), .rst_n(rst_n), .step(base_en), .enable(pie_en),
    .active(active), .mask(mask), .cnt_adv(cnt_adv),
    .hit(hit), .tick_q(tick_set));

  pid_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(stat_clr),
    .pf(flag_periodic), .irqf(flag_summary));

  p_tick_sets_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_set |-> flag_periodic && flag_summary);
  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_code) == '0 |-> !tick_set);
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_set |-> cnt[1:0] == 2'b00);
endmodule

// File: tb/periodic_irq_divider_test.sv
`timescale 1ns/1ps
module periodic_irq_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic pie_en = 1'b0;
  logic stat_clr = 1'b0;
  logic tick_set, flag_periodic, flag_summary;

  int errors = 0;
  int checks = 0;
  int unsigned mcnt = 0;
  logic exp_tick = 1'b0;
  logic exp_flag = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  periodic_irq_divider uut (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .rate_code(rate_code),
    .pie_en(pie_en), .stat_clr(stat_clr), .tick_set(tick_set),
    .flag_periodic(flag_periodic), .flag_summary(flag_summary));

  function automatic int unsigned period_of(input logic [3:0] c);
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 2 ** (int'(c) - 1);
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (strobes=%0d code=%0d)",
               req, what, act, exp, mcnt, rate_code);
    end
  endtask

  task automatic step(input string req, input logic bt, input logic [3:0] code,
                      input logic pie, input logic clr);
    int unsigned nxt;
    logic hit;
    @(negedge clk);
    base_en = bt; rate_code = code; pie_en = pie; stat_clr = clr;
    nxt = bt ? (mcnt + 1) % 32768 : mcnt;
    hit = bt && pie && (code != 4'd0) && ((nxt % period_of(code)) == 0);
    exp_tick = hit;
    exp_flag = hit ? 1'b1 : (clr ? 1'b0 : exp_flag);
    mcnt = nxt;
    @(posedge clk); #1;
    check(req, "tick_set", tick_set, exp_tick);
    check(req, "flag_periodic", flag_periodic, exp_flag);
    check(req, "flag_summary", flag_summary, exp_flag);
  endtask

  function automatic logic rnd_clr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[2:0] == 3'b000;
  endfunction

  task automatic run(input string req, input int n, input int gap,
                     input logic [3:0] code, input logic pie);
    for (int i = 0; i < n; i++)
      step(req, (i % gap) == 0, code, pie, rnd_clr());
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "tick_set", tick_set, 1'b0);
    check("R1", "flag_periodic", flag_periodic, 1'b0);
    check("R1", "flag_summary", flag_summary, 1'b0);
    // R1 first tick aligned to reset count, code 3 (period 4)
    run("R1", 20, 1, 4'd3, 1'b1);
    // R2 code 0 silent
    run("R2", 600, 1, 4'd0, 1'b1);
    // R4 slow remap of codes 1 and 2
    run("R4", 1200, 1, 4'd1, 1'b1);
    run("R4", 1200, 1, 4'd2, 1'b1);
    // R3 sweep of codes 3..15
    for (int c = 3; c < 16; c++) run("R3", 2100, 1, 4'(c), 1'b1);
    run("R3", 17000, 1, 4'd15, 1'b1);
    // R5 enable low: no ticks, counter keeps running
    run("R5", 300, 1, 4'd3, 1'b0);
    run("R5", 300, 1, 4'd4, 1'b1);
    // R10 sparse strobes
    run("R10", 900, 3, 4'd4, 1'b1);
    run("R10", 900, 7, 4'd3, 1'b1);
    // R6 rate changes without restart
    run("R6", 333, 1, 4'd5, 1'b1);
    run("R6", 517, 1, 4'd9, 1'b1);
    run("R6", 301, 2, 4'd4, 1'b1);
    run("R6", 700, 1, 4'd7, 1'b1);
    // R9 clear held high across ticks: set wins (R7 pulse width checked too)
    for (int i = 0; i < 400; i++) step("R9", 1'b1, 4'd3, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++)  step("R7", 1'b1, 4'd3, 1'b1, 1'b0);
    // R8 flags hold without clear, then drop on clear
    for (int i = 0; i < 50; i++)  step("R8", 1'b0, 4'd3, 1'b1, 1'b0);
    step("R8", 1'b0, 4'd3, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule